// File: doc/BRIEF.md
# Mode-Aware Watchdog Timer

This block is a watchdog made of an 8-bit base counter followed by a selectable power-of-two postscaler. What happens at a time-out depends on the core's current operating state. If the core is running code, the time-out produces a one-cycle reset request. If the core is idle or asleep, it produces a one-cycle wake request that brings the core out of its low-power state without resetting it. A sticky status bit records that a time-out happened.

Software restarts the count with a clear-watchdog strobe or a sleep strobe. Clock hardware can also restart it in two ways. The first is a clock-loss event, which counts only while the fail-safe clock monitor is enabled. The second is a write to the internal oscillator's frequency bits, which counts only while that oscillator is the system clock. A global enable input parks the whole watchdog at zero and keeps it silent.

Top module: `wdt_mode_guard`

## Requirements
- R1: The base counter advances by one on every cycle with `tick_en` high and is not cleared. It overflows once every 256 ticks.
- R2: With `post_sel` = k (0 to 15), a time-out occurs after exactly 256·2^k ticks counted from the last clear. The postscaler steps once per base overflow.
- R3: A time-out while `core_mode` is 0 (run) raises `reset_pulse` in the cycle after the tick edge that completes the period. `wake_pulse` stays low.
- R4: A time-out while `core_mode` is 1 (idle), 2 (sleep) or 3 (low-speed idle) raises `wake_pulse` with the same timing. `reset_pulse` stays low.
- R5: `clrwdt_stb` or `sleep_stb` clears both the base counter and the postscaler. A full period then restarts.
- R6: `clk_lost` clears both counters only while `fail_mon_en` is high. Otherwise it has no effect.
- R7: `osc_freq_wr` clears both counters only while `intosc_sysclk` is high. Otherwise it has no effect.
- R8: If any clear source is active in the cycle in which a time-out would occur, the clear wins. No pulse is issued and the period restarts.
- R9: `timeout_flag` is 0 after reset and is set by every time-out. Only `clrwdt_stb` or `sleep_stb` clears it. The clock-event clears leave it unchanged.
- R10: While `wdt_en` is low, both counters are held at zero and neither pulse is issued. After the enable returns, a full period is needed.
- R11: `wake_pulse` and `reset_pulse` are each high for exactly one cycle per time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_en | input | 1 | Global watchdog enable |
| tick_en | input | 1 | Base counter advance enable |
| clrwdt_stb | input | 1 | Clear-watchdog instruction strobe |
| sleep_stb | input | 1 | Sleep instruction strobe |
| clk_lost | input | 1 | Selected clock source lost |
| fail_mon_en | input | 1 | Fail-safe clock monitor enabled |
| osc_freq_wr | input | 1 | Write strobe for internal-oscillator frequency bits |
| intosc_sysclk | input | 1 | Internal oscillator is the system clock |
| core_mode | input | 2 | 0 run, 1 idle, 2 sleep, 3 low-speed idle |
| post_sel | input | 4 | Postscaler ratio select, 1:2^k |
| wake_pulse | output | 1 | One-cycle wake request |
| reset_pulse | output | 1 | One-cycle watchdog reset request |
| timeout_flag | output | 1 | Sticky time-out status |

## Verification
A corrupted base counter or postscaler cannot be seen at the ports until the next time-out. It shows up as a pulse that arrives after a number of ticks other than 256·2^k, or as no pulse at all. The delay before it becomes visible can therefore be a full period. A clear that is lost or wrongly accepted shows the same way, as a shortened or lengthened interval to the next pulse. A mode decode error shows in the very cycle of the time-out, as the wrong pulse. A flag fault is visible one cycle after the strobe or time-out that should have changed it.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  typedef enum logic [1:0] {
    CORE_RUN   = 2'd0,
    CORE_IDLE  = 2'd1,
    CORE_SLEEP = 2'd2,
    CORE_DOZE  = 2'd3
  } core_mode_e;

  typedef struct packed {
    logic sw_clr;   // software strobes: also drop the status flag
    logic any_clr;  // every accepted clear source
  } wdt_clear_t;

endpackage

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl
  import wdt_guard_pkg::*;
(
  input  logic       clrwdt_stb,
  input  logic       sleep_stb,
  input  logic       clk_lost,
  input  logic       fail_mon_en,
  input  logic       osc_freq_wr,
  input  logic       intosc_sysclk,
  output wdt_clear_t clr
);

  logic hw_lost_clr;
  logic hw_freq_clr;

  always_comb begin
    hw_lost_clr = clk_lost & fail_mon_en;
    hw_freq_clr = osc_freq_wr & intosc_sysclk;
    clr.sw_clr  = clrwdt_stb | sleep_stb;
    clr.any_clr = clr.sw_clr | hw_lost_clr | hw_freq_clr;
  end

endmodule

// File: rtl/wdt_base_cnt.sv
module wdt_base_cnt #(
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              clr,
  output logic [BASE_W-1:0] cnt,
  output logic              wrap
);

  localparam logic [BASE_W-1:0] CNT_MAX = '1;

  logic [BASE_W-1:0] cnt_d;
  logic              cnt_ce;

  always_comb begin
    wrap   = en & tick & ~clr & (cnt == CNT_MAX);
    cnt_ce = ~en | clr | tick;
    if (!en || clr) cnt_d = '0;
    else            cnt_d = cnt + BASE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_ce) cnt <= cnt_d;
  end

  // R1: an unclear tick moves the count forward by one
  a_r1_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !clr) |=> (cnt == $past(cnt) + BASE_W'(1)));

  // R10: disabled watchdog keeps the base count at zero
  a_r10_base_held: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);

  localparam int POST_W = (1 << SEL_W) - 1;

  logic [POST_W-1:0] cnt;
  logic [POST_W-1:0] cnt_d;
  logic [POST_W-1:0] limit;
  logic              cnt_ce;

  // limit = 2^sel - 1, built as a thermometer code
  always_comb begin
    for (int i = 0; i < POST_W; i++) begin
      limit[i] = (i < int'(sel));
    end
  end

  always_comb begin
    expire = en & ~clr & step & (cnt >= limit);
    cnt_ce = ~en | clr | step;
    if (!en || clr)   cnt_d = '0;
    else if (expire)  cnt_d = '0;
    else              cnt_d = cnt + POST_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_ce) cnt <= cnt_d;
  end

  // R2: postscaler advances once per base overflow until its limit
  a_r2_post_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && step && !expire) |=> (cnt == $past(cnt) + POST_W'(1)));

  // R5: any accepted clear empties the postscaler
  a_r5_post_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr) |=> (cnt == '0));

  // R10: disabled watchdog keeps the postscaler at zero
  a_r10_post_held: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       expire,
  input  wdt_clear_t clr,
  input  core_mode_e mode,
  output logic       wake_pulse,
  output logic       reset_pulse,
  output logic       timeout_flag
);

  logic hit;
  logic wake_d;
  logic reset_d;
  logic flag_d;

  always_comb begin
    hit     = en & expire & ~clr.any_clr;
    reset_d = hit & (mode == CORE_RUN);
    wake_d  = hit & (mode != CORE_RUN);
    if (clr.sw_clr)  flag_d = 1'b0;
    else if (hit)    flag_d = 1'b1;
    else             flag_d = timeout_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_pulse   <= 1'b0;
      reset_pulse  <= 1'b0;
      timeout_flag <= 1'b0;
    end else begin
      wake_pulse   <= wake_d;
      reset_pulse  <= reset_d;
      timeout_flag <= flag_d;
    end
  end

  // R3: a reset request only follows a time-out taken in run mode
  a_r3_reset_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |-> ($past(mode) == CORE_RUN));

  // R4: a wake request only follows a time-out in a power-managed mode
  a_r4_wake_not_run: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> ($past(mode) != CORE_RUN));

  // R8: a clear in the cycle before blocks both pulses
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr.any_clr |=> !(wake_pulse || reset_pulse));

  // R9: software strobes drop the status flag
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr.sw_clr |=> !timeout_flag);

  // R9: every pulse comes with the status flag set
  a_r9_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse || reset_pulse) |-> timeout_flag);

  // R11: pulses last one cycle
  a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse || reset_pulse) |=> !(wake_pulse || reset_pulse));

  // R10: no request follows a disabled cycle
  a_r10_silent_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(wake_pulse || reset_pulse));

endmodule

// File: rtl/wdt_mode_guard.sv
module wdt_mode_guard
  import wdt_guard_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_en,
  input  logic             tick_en,
  input  logic             clrwdt_stb,
  input  logic             sleep_stb,
  input  logic             clk_lost,
  input  logic             fail_mon_en,
  input  logic             osc_freq_wr,
  input  logic             intosc_sysclk,
  input  logic [1:0]       core_mode,
  input  logic [SEL_W-1:0] post_sel,
  output logic             wake_pulse,
  output logic             reset_pulse,
  output logic             timeout_flag
);

  wdt_clear_t        clr;
  logic [BASE_W-1:0] base_cnt;
  logic              base_wrap;
  logic              post_expire;
  core_mode_e        mode_e;

  assign mode_e = core_mode_e'(core_mode);

  wdt_clear_ctl u_clear (
    .clrwdt_stb    (clrwdt_stb),
    .sleep_stb     (sleep_stb),
    .clk_lost      (clk_lost),
    .fail_mon_en   (fail_mon_en),
    .osc_freq_wr   (osc_freq_wr),
    .intosc_sysclk (intosc_sysclk),
    .clr           (clr)
  );

  wdt_base_cnt #(.BASE_W(BASE_W)) u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (wdt_en),
    .tick  (tick_en),
    .clr   (clr.any_clr),
    .cnt   (base_cnt),
    .wrap  (base_wrap)
  );

  wdt_postscaler #(.SEL_W(SEL_W)) u_post (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (wdt_en),
    .clr    (clr.any_clr),
    .step   (base_wrap),
    .sel    (post_sel),
    .expire (post_expire)
  );

  wdt_action u_action (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (wdt_en),
    .expire       (post_expire),
    .clr          (clr),
    .mode         (mode_e),
    .wake_pulse   (wake_pulse),
    .reset_pulse  (reset_pulse),
    .timeout_flag (timeout_flag)
  );

  // R5: a software clear leaves the base count at zero
  a_r5_base_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_en && (clrwdt_stb || sleep_stb)) |=> (base_cnt == '0));

endmodule

// File: tb/wdt_mode_guard_tb.sv
module wdt_mode_guard_tb;

  logic       clk;
  logic       rst_n;
  logic       wdt_en;
  logic       tick_en;
  logic       clrwdt_stb;
  logic       sleep_stb;
  logic       clk_lost;
  logic       fail_mon_en;
  logic       osc_freq_wr;
  logic       intosc_sysclk;
  logic [1:0] core_mode;
  logic [3:0] post_sel;
  logic       wake_pulse;
  logic       reset_pulse;
  logic       timeout_flag;

  int checks   = 0;
  int failures = 0;

  wdt_mode_guard u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .wdt_en        (wdt_en),
    .tick_en       (tick_en),
    .clrwdt_stb    (clrwdt_stb),
    .sleep_stb     (sleep_stb),
    .clk_lost      (clk_lost),
    .fail_mon_en   (fail_mon_en),
    .osc_freq_wr   (osc_freq_wr),
    .intosc_sysclk (intosc_sysclk),
    .core_mode     (core_mode),
    .post_sel      (post_sel),
    .wake_pulse    (wake_pulse),
    .reset_pulse   (reset_pulse),
    .timeout_flag  (timeout_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    tick_en = 1'b0;
  endtask

  // one cycle with a strobe held, tick low
  task automatic strobe(input int which);
    case (which)
      0: clrwdt_stb  = 1'b1;
      1: sleep_stb   = 1'b1;
      2: clk_lost    = 1'b1;
      default: osc_freq_wr = 1'b1;
    endcase
    @(negedge clk);
    clrwdt_stb = 1'b0; sleep_stb = 1'b0; clk_lost = 1'b0; osc_freq_wr = 1'b0;
  endtask

  // tick until a pulse appears; check the count and which pulse fired
  task automatic measure(input string req, input int exp_n, input bit exp_wake);
    int n;
    bit seen;
    n = 0; seen = 0;
    tick_en = 1'b1;
    for (int i = 0; i < exp_n + 300; i++) begin
      @(negedge clk);
      n++;
      if (wake_pulse || reset_pulse) begin seen = 1; break; end
    end
    tick_en = 1'b0;
    check(seen && n == exp_n, req, "ticks to time-out", n, exp_n);
    check(wake_pulse == exp_wake && reset_pulse == !exp_wake, req,
          "pulse kind (wake)", int'(wake_pulse), int'(exp_wake));
    check(timeout_flag == 1'b1, "R9", "flag after time-out", int'(timeout_flag), 1);
    @(negedge clk);
    check(!wake_pulse && !reset_pulse, "R11", "pulse width",
          int'(wake_pulse | reset_pulse), 0);
  endtask

  task automatic t_reset_state;
    check(!wake_pulse && !reset_pulse, "R3", "pulses after reset",
          int'(wake_pulse | reset_pulse), 0);
    check(timeout_flag == 1'b0, "R9", "flag after reset", int'(timeout_flag), 0);
  endtask

  task automatic t_modes;
    post_sel = 4'd0; core_mode = 2'd2;
    measure("R4", 256, 1'b1);
    post_sel = 4'd1; core_mode = 2'd0;
    measure("R3", 512, 1'b0);
    post_sel = 4'd3; core_mode = 2'd1;
    measure("R2", 2048, 1'b1);
    post_sel = 4'd0; core_mode = 2'd3;
    measure("R4", 256, 1'b1);
    post_sel = 4'd4; core_mode = 2'd0;
    measure("R2", 4096, 1'b0);
  endtask

  task automatic t_sw_clears;
    core_mode = 2'd2; post_sel = 4'd0;
    ticks(200); strobe(0);
    check(timeout_flag == 1'b0, "R9", "flag after clrwdt", int'(timeout_flag), 0);
    measure("R5", 256, 1'b1);
    ticks(100); strobe(1);
    check(timeout_flag == 1'b0, "R9", "flag after sleep strobe", int'(timeout_flag), 0);
    measure("R5", 256, 1'b1);
    post_sel = 4'd2;
    ticks(700); strobe(0);
    measure("R5", 1024, 1'b1);
    post_sel = 4'd0;
  endtask

  task automatic t_clock_clears;
    core_mode = 2'd1; post_sel = 4'd0;
    fail_mon_en = 1'b0;
    ticks(200); strobe(2);
    measure("R6", 56, 1'b1);
    fail_mon_en = 1'b1;
    ticks(200); strobe(2);
    check(timeout_flag == 1'b1, "R9", "flag kept by clock-loss clear", int'(timeout_flag), 1);
    measure("R6", 256, 1'b1);
    fail_mon_en = 1'b0;
    intosc_sysclk = 1'b0;
    ticks(150); strobe(3);
    measure("R7", 106, 1'b1);
    intosc_sysclk = 1'b1;
    ticks(150); strobe(3);
    check(timeout_flag == 1'b1, "R9", "flag kept by freq write clear", int'(timeout_flag), 1);
    measure("R7", 256, 1'b1);
    intosc_sysclk = 1'b0;
  endtask

  task automatic t_same_cycle;
    core_mode = 2'd0; post_sel = 4'd0;
    strobe(0);
    ticks(255);
    tick_en = 1'b1; clrwdt_stb = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; clrwdt_stb = 1'b0;
    check(!wake_pulse && !reset_pulse, "R8", "pulse despite clear",
          int'(wake_pulse | reset_pulse), 0);
    check(timeout_flag == 1'b0, "R8", "flag despite clear", int'(timeout_flag), 0);
    measure("R8", 256, 1'b0);
  endtask

  task automatic t_disable;
    int pulses;
    core_mode = 2'd2; post_sel = 4'd0;
    ticks(200);
    wdt_en = 1'b0;
    pulses = 0;
    tick_en = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (wake_pulse || reset_pulse) pulses++;
    end
    tick_en = 1'b0;
    check(pulses == 0, "R10", "pulses while disabled", pulses, 0);
    wdt_en = 1'b1;
    measure("R10", 256, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wdt_en = 1'b1; tick_en = 1'b0;
    clrwdt_stb = 1'b0; sleep_stb = 1'b0; clk_lost = 1'b0; fail_mon_en = 1'b0;
    osc_freq_wr = 1'b0; intosc_sysclk = 1'b0; core_mode = 2'd0; post_sel = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_modes();
    t_sw_clears();
    t_clock_clears();
    t_same_cycle();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule